// File: doc/BRIEF.md
# Line-to-Message Interrupt Redirection Controller

This block collects a set of wired interrupt inputs and turns each qualifying event into a message-signaled interrupt. A message is a single write transaction with an address and a data word. Software sets the block up through an indirect register scheme. It writes an internal index into a selector register, then reads or writes the chosen internal register through a window register. The internal space holds a read-only identification word and a redirection table. The table has two 32-bit words per input line.

For each line the table word pair sets a mask, the trigger type (edge or level), the polarity, an 8-bit vector value sent as message data, and a destination (id and extended id) that forms the upper half of the message address. A level line sends one message and then waits in service. A write to the end-of-interrupt register whose data matches the line's vector re-arms the line, and a line that is still asserted then sends again. When several lines want service at the same time, the lowest-numbered one goes first. Messages leave through a valid/ready handshake.

Top module: `irq_msg_redirector`

## Requirements
- R1: After reset the selector reads 0, no message is offered, every low table word reads 0x0001_0000 (masked), and every high table word reads 0.
- R2: Register offsets: selector at 0x00 (bits 7:0), window at 0x10, end-of-interrupt at 0x40. Entry n has its low word at index 0x10+2n and its high word at 0x11+2n. Low word: bit 16 mask, bit 15 level trigger, bit 13 active-low, bits 7:0 vector; all other low bits read 0. High word: bits 31:24 id, bits 23:16 extended id; bits 15:0 read 0.
- R3: Index 0x01 reads {8'h00, NUM_LINES-1, 8'h00, VERSION} and ignores writes. Indices that are not implemented read 0.
- R4: A masked line sends no message, whatever its input does.
- R5: A level line that is asserted and unmasked sends one message and then no more until an end-of-interrupt write whose bits 7:0 equal its vector. If the line is still asserted then, a new message follows. An end-of-interrupt write with any other value has no effect on it.
- R6: An edge line sends one message for each inactive-to-active transition after polarity is applied (active-low: a falling pin). A held level or an inactive-going transition sends nothing.
- R7: When several lines request at once, the lowest-numbered line is served first, and the others follow in turn.
- R8: A message carries address {id, eid, 16'h0000} and data {24'h0, vector}. Address and data stay stable while valid is high and ready is low.
- R9: Inputs pass through a two-stage synchronizer. A message is offered within 4 clock cycles of an input change that calls for one, when the output is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| irq_pins | input | NUM_LINES | Asynchronous interrupt input lines |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Message accepted by the receiver |
| msg_addr | output | 32 | Message write address |
| msg_data | output | 32 | Message write data |

## Verification
The bench builds the block with NUM_LINES = 4 and VERSION = 0x5A. This places the last table word at index 0x17 and the first unimplemented index at 0x18, so both sides of the table boundary can be checked by reading. Four lines are enough to run one masked level line, one level line with matching and non-matching end-of-interrupt writes, and one active-low edge line at the same time. It also allows a simultaneous request from line 0 and line 3 with a stalled receiver, which shows the priority order and that the held message stays stable.

// File: rtl/irqr_pkg.sv
`timescale 1ns/1ps
package irqr_pkg;

    localparam logic [6:0] OFS_SEL = 7'h00;
    localparam logic [6:0] OFS_WIN = 7'h10;
    localparam logic [6:0] OFS_EOI = 7'h40;

    localparam logic [7:0] IDX_IDENT = 8'h01;
    localparam logic [7:0] IDX_TABLE = 8'h10;

    localparam int BIT_MASK  = 16;
    localparam int BIT_LEVEL = 15;
    localparam int BIT_ALOW  = 13;

    typedef struct packed {
        logic       mask;
        logic       level;
        logic       act_low;
        logic [7:0] vec;
        logic [7:0] dst_id;
        logic [7:0] dst_eid;
    } rte_t;

    typedef struct packed {
        logic [31:0] addr;
        logic [31:0] data;
    } msg_t;

    function automatic rte_t rte_reset();
        rte_t e;
        e      = '0;
        e.mask = 1'b1;
        return e;
    endfunction

    function automatic logic [31:0] rte_lo(rte_t e);
        logic [31:0] w;
        w            = '0;
        w[BIT_MASK]  = e.mask;
        w[BIT_LEVEL] = e.level;
        w[BIT_ALOW]  = e.act_low;
        w[7:0]       = e.vec;
        return w;
    endfunction

    function automatic logic [31:0] rte_hi(rte_t e);
        return {e.dst_id, e.dst_eid, 16'h0000};
    endfunction

    function automatic rte_t rte_put_lo(rte_t e, logic [31:0] w);
        rte_t r;
        r         = e;
        r.mask    = w[BIT_MASK];
        r.level   = w[BIT_LEVEL];
        r.act_low = w[BIT_ALOW];
        r.vec     = w[7:0];
        return r;
    endfunction

    function automatic rte_t rte_put_hi(rte_t e, logic [31:0] w);
        rte_t r;
        r         = e;
        r.dst_id  = w[31:24];
        r.dst_eid = w[23:16];
        return r;
    endfunction

    function automatic msg_t rte_msg(rte_t e);
        msg_t m;
        m.addr = {e.dst_id, e.dst_eid, 16'h0000};
        m.data = {24'h000000, e.vec};
        return m;
    endfunction

endpackage

// File: rtl/irqr_sync.sv
`timescale 1ns/1ps
module irqr_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q_sync <= '0;
        end else begin
            stage1 <= d_async;
            q_sync <= stage1;
        end
    end
endmodule

// File: rtl/irqr_line.sv
`timescale 1ns/1ps
module irqr_line
    import irqr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pin_s,
    input  rte_t cfg,
    input  logic eoi_hit,
    input  logic grant,
    output logic req
);
    logic act;
    logic act_d;
    logic edge_pend;
    logic in_svc;

    assign act = pin_s ^ cfg.act_low;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_d     <= 1'b0;
            edge_pend <= 1'b0;
            in_svc    <= 1'b0;
        end else begin
            act_d <= act;
            if (cfg.level)
                edge_pend <= 1'b0;
            else if (!cfg.mask && act && !act_d)
                edge_pend <= 1'b1;
            else if (grant)
                edge_pend <= 1'b0;

            if (!cfg.level)
                in_svc <= 1'b0;
            else if (grant)
                in_svc <= 1'b1;
            else if (eoi_hit)
                in_svc <= 1'b0;
        end
    end

    assign req = !cfg.mask && (cfg.level ? (act && !in_svc) : edge_pend);

    AST_LEVEL_HELD: assert property (@(posedge clk) disable iff (rst)
        (grant && cfg.level) |=> (in_svc || !cfg.level)); // R5

    AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
        grant |-> req); // R7
endmodule

// File: rtl/irqr_arb.sv
`timescale 1ns/1ps
module irqr_arb #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    always_comb begin
        grant = '0;
        if (en) begin
            for (int i = N - 1; i >= 0; i--) begin
                if (req[i]) grant = N'(1) << i;
            end
        end
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant)); // R7

    AST_GRANT_LOWEST: assert property (@(posedge clk) disable iff (rst)
        (grant != '0) |-> ((req & (grant - N'(1))) == '0)); // R7

    AST_GRANT_IDLE_ONLY: assert property (@(posedge clk) disable iff (rst)
        !en |-> (grant == '0)); // R8
endmodule

// File: rtl/irq_msg_redirector.sv
`timescale 1ns/1ps
module irq_msg_redirector
    import irqr_pkg::*;
#(
    parameter int         NUM_LINES = 8,
    parameter logic [7:0] VERSION   = 8'h21
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_we,
    input  logic [6:0]           reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic [NUM_LINES-1:0] irq_pins,
    output logic                 msg_valid,
    input  logic                 msg_ready,
    output logic [31:0]          msg_addr,
    output logic [31:0]          msg_data
);
    localparam int LW      = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
    localparam int TBL_END = int'(IDX_TABLE) + 2 * NUM_LINES;

    logic [7:0]           sel;
    rte_t                 tbl [NUM_LINES];
    logic [NUM_LINES-1:0] pins_s;
    logic [NUM_LINES-1:0] req;
    logic [NUM_LINES-1:0] grant;
    logic [NUM_LINES-1:0] eoi_hit;
    logic [NUM_LINES-1:0] mask_vec;
    logic [7:0]           tbl_off;
    logic                 tbl_hit;
    logic [LW-1:0]        ent;
    logic [31:0]          win_rd;
    logic [LW-1:0]        win_idx;
    msg_t                 next_msg;
    logic                 unused_wbits;

    assign unused_wbits = ^{reg_wdata[14], reg_wdata[12:8]};

    // Window decode
    assign tbl_off = sel - IDX_TABLE;
    assign tbl_hit = (sel >= IDX_TABLE) && (int'(sel) < TBL_END);
    assign ent     = tbl_off[LW:1];

    always_comb begin
        win_rd = '0;
        if (sel == IDX_IDENT)
            win_rd = {8'h00, 8'(NUM_LINES - 1), 8'h00, VERSION};
        else if (tbl_hit)
            win_rd = tbl_off[0] ? rte_hi(tbl[ent]) : rte_lo(tbl[ent]);
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == OFS_SEL)      reg_rdata = {24'h0, sel};
        else if (reg_addr == OFS_WIN) reg_rdata = win_rd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel <= '0;
            for (int i = 0; i < NUM_LINES; i++) tbl[i] <= rte_reset();
        end else if (reg_we) begin
            if (reg_addr == OFS_SEL)
                sel <= reg_wdata[7:0];
            else if (reg_addr == OFS_WIN && tbl_hit) begin
                if (tbl_off[0]) tbl[ent] <= rte_put_hi(tbl[ent], reg_wdata);
                else            tbl[ent] <= rte_put_lo(tbl[ent], reg_wdata);
            end
        end
    end

    irqr_sync #(.WIDTH(NUM_LINES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (irq_pins),
        .q_sync  (pins_s)
    );

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        assign eoi_hit[g]  = reg_we && (reg_addr == OFS_EOI) && (reg_wdata[7:0] == tbl[g].vec);
        assign mask_vec[g] = tbl[g].mask;
        irqr_line u_line (
            .clk     (clk),
            .rst     (rst),
            .pin_s   (pins_s[g]),
            .cfg     (tbl[g]),
            .eoi_hit (eoi_hit[g]),
            .grant   (grant[g]),
            .req     (req[g])
        );
    end

    irqr_arb #(.N(NUM_LINES)) u_arb (
        .clk   (clk),
        .rst   (rst),
        .en    (!msg_valid),
        .req   (req),
        .grant (grant)
    );

    always_comb begin
        win_idx = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (grant[i]) win_idx = LW'(i);
        end
        next_msg = rte_msg(tbl[win_idx]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            msg_valid <= 1'b0;
            msg_addr  <= '0;
            msg_data  <= '0;
        end else if (msg_valid) begin
            if (msg_ready) msg_valid <= 1'b0;
        end else if (grant != '0) begin
            msg_valid <= 1'b1;
            msg_addr  <= next_msg.addr;
            msg_data  <= next_msg.data;
        end
    end

    AST_MSG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data))); // R8

    AST_MASKED_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
        (grant & mask_vec) == '0); // R4
endmodule

// File: tb/test_irq_msg_redirector.sv
`timescale 1ns/1ps
module test_irq_msg_redirector;
    localparam int NL = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_we = 1'b0;
    logic [6:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NL-1:0] irq_pins = '0;
    logic          msg_valid;
    logic          msg_ready = 1'b0;
    logic [31:0]   msg_addr;
    logic [31:0]   msg_data;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_msg_redirector #(.NUM_LINES(NL), .VERSION(8'h5A)) i_irq_msg_redirector (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_pins  (irq_pins),
        .msg_valid (msg_valid),
        .msg_ready (msg_ready),
        .msg_addr  (msg_addr),
        .msg_data  (msg_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 7'h00; reg_wdata = '0;
    endtask

    task automatic wr_idx(input logic [7:0] idx, input logic [31:0] d);
        wr(7'h00, {24'h0, idx});
        wr(7'h10, d);
    endtask

    task automatic rd_idx(input logic [7:0] idx, output logic [31:0] d);
        wr(7'h00, {24'h0, idx});
        reg_addr = 7'h10;
        #1 d = reg_rdata;
        reg_addr = 7'h00;
    endtask

    task automatic eoi(input logic [7:0] v);
        wr(7'h40, {24'h0, v});
    endtask

    task automatic expect_msg(input string tag, input logic [31:0] ea, input logic [31:0] ed);
        int waited = 0;
        while (!msg_valid && waited < 4) begin
            @(negedge clk);
            waited++;
        end
        chk({tag, " valid"}, {31'h0, msg_valid}, 32'h1);
        chk({tag, " addr"}, msg_addr, ea);
        chk({tag, " data"}, msg_data, ed);
        msg_ready = 1'b1;
        @(negedge clk);
        msg_ready = 1'b0;
    endtask

    task automatic expect_quiet(input string tag, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk({tag, " quiet"}, {31'h0, msg_valid}, 32'h0);
        end
    endtask

    task automatic release_line(input int n, input logic [7:0] v);
        irq_pins[n] = 1'b0;
        repeat (3) @(negedge clk);
        eoi(v);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk("R1 msg_valid after reset", {31'h0, msg_valid}, 32'h0);
        reg_addr = 7'h00;
        #1 chk("R1 selector after reset", reg_rdata, 32'h0);
        rd_idx(8'h10, d); chk("R1 entry0 low", d, 32'h0001_0000);
        rd_idx(8'h16, d); chk("R1 entry3 low", d, 32'h0001_0000);
        rd_idx(8'h17, d); chk("R1 entry3 high", d, 32'h0);
    endtask

    task automatic t_regs;
        logic [31:0] d;
        wr_idx(8'h12, 32'hFFFF_FFFF);
        rd_idx(8'h12, d); chk("R2 low word fields", d, 32'h0001_A0FF);
        wr_idx(8'h13, 32'hFFFF_FFFF);
        rd_idx(8'h13, d); chk("R2 high word fields", d, 32'hFFFF_0000);
        reg_addr = 7'h00;
        #1 chk("R2 selector readback", reg_rdata, 32'h13);
        reg_addr = 7'h20;
        #1 chk("R2 undefined offset reads 0", reg_rdata, 32'h0);
        reg_addr = 7'h00;
        wr_idx(8'h12, 32'h0001_0000);
        wr_idx(8'h13, 32'h0);
        rd_idx(8'h12, d); chk("R2 low word restore", d, 32'h0001_0000);
    endtask

    task automatic t_version;
        logic [31:0] d;
        rd_idx(8'h01, d); chk("R3 ident word", d, 32'h0003_005A);
        wr_idx(8'h01, 32'h0);
        rd_idx(8'h01, d); chk("R3 ident ignores write", d, 32'h0003_005A);
        rd_idx(8'h18, d); chk("R3 past table end", d, 32'h0);
        rd_idx(8'h02, d); chk("R3 unimplemented 0x02", d, 32'h0);
        rd_idx(8'h0F, d); chk("R3 unimplemented 0x0F", d, 32'h0);
    endtask

    task automatic t_mask;
        wr_idx(8'h11, 32'h1122_0000);
        wr_idx(8'h10, 32'h0001_8010);
        irq_pins[0] = 1'b1;
        expect_quiet("R4 masked level line", 8);
        wr_idx(8'h10, 32'h0000_8010);
        expect_msg("R4 unmasked line", 32'h1122_0000, 32'h10);
        release_line(0, 8'h10);
        expect_quiet("R4 released line", 6);
    endtask

    task automatic t_level;
        wr_idx(8'h13, 32'hA107_0000);
        wr_idx(8'h12, 32'h0000_8031);
        irq_pins[1] = 1'b1;
        expect_msg("R9 R5 level first", 32'hA107_0000, 32'h31);
        expect_quiet("R5 in service", 8);
        eoi(8'h30);
        expect_quiet("R5 wrong eoi value", 8);
        eoi(8'h31);
        expect_msg("R5 eoi rearm", 32'hA107_0000, 32'h31);
        release_line(1, 8'h31);
        expect_quiet("R5 deasserted after eoi", 6);
    endtask

    task automatic t_edge;
        irq_pins[2] = 1'b1;
        repeat (3) @(negedge clk);
        wr_idx(8'h15, 32'h5C3D_0000);
        wr_idx(8'h14, 32'h0000_2042);
        expect_quiet("R6 inactive high pin", 4);
        irq_pins[2] = 1'b0;
        expect_msg("R9 R6 falling edge", 32'h5C3D_0000, 32'h42);
        expect_quiet("R6 held active", 8);
        irq_pins[2] = 1'b1;
        expect_quiet("R6 inactive-going edge", 6);
        irq_pins[2] = 1'b0;
        expect_msg("R6 second edge", 32'h5C3D_0000, 32'h42);
        wr_idx(8'h14, 32'h0001_2042);
        irq_pins[2] = 1'b1;
        expect_quiet("R6 masked edge", 6);
    endtask

    task automatic t_priority;
        logic [31:0] a0;
        wr_idx(8'h17, 32'h7701_0000);
        wr_idx(8'h16, 32'h0000_8033);
        irq_pins[0] = 1'b1;
        irq_pins[3] = 1'b1;
        repeat (4) @(negedge clk);
        chk("R7 valid on contention", {31'h0, msg_valid}, 32'h1);
        chk("R7 lowest line first", msg_addr, 32'h1122_0000);
        a0 = msg_data;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R8 held valid", {31'h0, msg_valid}, 32'h1);
            chk("R8 held addr", msg_addr, 32'h1122_0000);
            chk("R8 held data", msg_data, a0);
        end
        chk("R8 line0 data", msg_data, 32'h10);
        msg_ready = 1'b1;
        @(negedge clk);
        msg_ready = 1'b0;
        expect_msg("R7 next line served", 32'h7701_0000, 32'h33);
        expect_quiet("R7 both in service", 6);
        release_line(0, 8'h10);
        release_line(3, 8'h33);
        expect_quiet("R7 all released", 6);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regs();
        t_version();
        t_mask();
        t_level();
        t_edge();
        t_priority();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule